// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limit Gate

This block sits between a digital PWM modulator and the gate-drive enables of a synchronous buck stage. Every cycle it takes the modulator's on-demand level, a one-cycle pulse marking each switching-period start, and two comparator flags: one for high-side overcurrent and one for valley (low-side) overcurrent. From these it produces the high-side and low-side drive enables. Dead-time insertion happens downstream.

The high-side flag is masked for a programmable number of system clock cycles after each high-side turn-on. This hides switching noise. Once that window has expired, the flag ends the on-time at the next edge, and the high side stays off until the next period starts. The valley flag acts differently: while the low side conducts and the flag is high, the high side may not turn on. The high side resumes as soon as the flag clears and the modulator still asks for it. Each kind of limit has its own event pulse. A 2-bit limit-level select is registered and passed on to the valley-threshold DAC.

No stream data passes through the block. All pins are plain control levels or pulses, with no handshake and no back-pressure. Reset is active-low and synchronous.

Top module: `ocp_gate`

## Requirements
- R1: While rst_n is low, hs_en, ls_en, hs_evt, ls_evt and dac_lvl are all zero at the next clock edge.
- R2: Out of reset, ls_en is the complement of hs_en from the first clock edge onward, and the two are never high together.
- R3: With no limit active, hs_en follows pwm_dem one clock later.
- R4: hs_oc is ignored in the first BLANK_CYC cycles in which hs_en is high after each rising edge of hs_en.
- R5: hs_oc sampled high after the blanking window, while hs_en is high, drives hs_en low at the next edge. At that same edge, hs_evt pulses high for one cycle.
- R6: After a truncation, hs_en stays low until the cycle following an sw_tick pulse, even if pwm_dem stays high.
- R7: While hs_en is low, ls_en is high and ls_oc is high, hs_en does not rise. One edge after ls_oc is sampled low, hs_en rises if pwm_dem is high.
- R8: At the edge that samples sw_tick high, ls_evt pulses for one cycle if ls_en and ls_oc were sampled high together in any cycle since the previous sw_tick (this cycle included). ls_oc seen while ls_en is low does not count. hs_oc never drives ls_evt, and ls_oc never drives hs_evt.
- R9: dac_lvl takes lvl_sel one cycle later, with codes 00 = 3 A, 01 = 4 A and 10 = 5 A; code 11 is output as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_dem | input | 1 | Modulator on-demand level for the high side |
| sw_tick | input | 1 | One-cycle pulse marking each switching-period start |
| hs_oc | input | 1 | High-side overcurrent comparator flag |
| ls_oc | input | 1 | Valley (low-side) overcurrent comparator flag |
| lvl_sel | input | 2 | Valley limit level select |
| hs_en | output | 1 | High-side drive enable |
| ls_en | output | 1 | Low-side drive enable |
| hs_evt | output | 1 | One-cycle pulse on a high-side truncation |
| ls_evt | output | 1 | Per-period valley limit event pulse |
| dac_lvl | output | 2 | Registered, clamped level code for the threshold DAC |

## Verification
The high-side flag is first raised for exactly the blanking length and then dropped, and later raised for one cycle longer. The first pattern must leave the on-time whole, and the second must truncate it on the first cycle past the window. A truncated period is held with pwm_dem still high, which separates a latched truncation from plain demand-following. The valley flag is applied once during low-side conduction and once during high-side conduction. This shows that only the first inhibits turn-on and raises the period event, and a period with no valley flag at all shows that the event stays quiet.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    LVL_3A     = 2'b00,
    LVL_4A     = 2'b01,
    LVL_5A     = 2'b10,
    LVL_5A_ALT = 2'b11
  } lvl_e;

  // Folds the spare code onto the highest real level.
  function automatic logic [1:0] clamp_level(input logic [1:0] sel);
    logic [1:0] r;
    unique case (sel)
      LVL_3A:  r = LVL_3A;
      LVL_4A:  r = LVL_4A;
      default: r = LVL_5A;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int unsigned BLANK_CYC = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(BLANK_CYC + 2);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (start)                  cnt_q <= LOAD;
    else if (active && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/ocp_valley_mon.sv
module ocp_valley_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic valley,
  input  logic sw_tick,
  output logic evt
);
  logic seen_q;
  logic evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      evt_q  <= 1'b0;
    end else if (sw_tick) begin
      evt_q  <= seen_q | valley;
      seen_q <= 1'b0;
    end else begin
      evt_q  <= 1'b0;
      seen_q <= seen_q | valley;
    end
  end

  assign evt = evt_q;
endmodule

// File: rtl/ocp_level_map.sv
module ocp_level_map
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic [1:0] lvl
);
  logic [1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 2'b00;
    else        lvl_q <= clamp_level(sel);
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/ocp_gate.sv
module ocp_gate #(
  parameter int unsigned BLANK_CYC = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_dem,
  input  logic       sw_tick,
  input  logic       hs_oc,
  input  logic       ls_oc,
  input  logic [1:0] lvl_sel,
  output logic       hs_en,
  output logic       ls_en,
  output logic       hs_evt,
  output logic       ls_evt,
  output logic [1:0] dac_lvl
);
  logic hs_q, ls_q, trunc_q, hs_evt_q;
  logic hs_d, blank_done, cut, valley, trunc_live, turn_on;

  // Valley limit only counts while the low side is conducting.
  assign valley     = ls_q & ls_oc;
  assign cut        = hs_q & blank_done & hs_oc;
  assign trunc_live = trunc_q & ~sw_tick;

  always_comb begin
    if (cut)       hs_d = 1'b0;
    else if (hs_q) hs_d = pwm_dem;
    else           hs_d = pwm_dem & ~trunc_live & ~valley;
  end

  assign turn_on = hs_d & ~hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q     <= 1'b0;
      ls_q     <= 1'b0;
      trunc_q  <= 1'b0;
      hs_evt_q <= 1'b0;
    end else begin
      hs_q     <= hs_d;
      ls_q     <= ~hs_d;
      hs_evt_q <= cut;
      if (cut)          trunc_q <= 1'b1;
      else if (sw_tick) trunc_q <= 1'b0;
    end
  end

  ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (turn_on),
    .active (hs_q),
    .done   (blank_done)
  );

  ocp_valley_mon u_valley (
    .clk     (clk),
    .rst_n   (rst_n),
    .valley  (valley),
    .sw_tick (sw_tick),
    .evt     (ls_evt)
  );

  ocp_level_map u_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (lvl_sel),
    .lvl   (dac_lvl)
  );

  assign hs_en  = hs_q;
  assign ls_en  = ls_q;
  assign hs_evt = hs_evt_q;
endmodule

// File: rtl/ocp_gate_chk.sv
module ocp_gate_chk #(
  parameter int unsigned BLANK_CYC = 11
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_tick,
  input logic       ls_oc,
  input logic       hs_en,
  input logic       ls_en,
  input logic       hs_evt,
  input logic       ls_evt,
  input logic [1:0] dac_lvl
);
  localparam int unsigned OW = $clog2(BLANK_CYC + 2);
  localparam logic [OW-1:0] SAT = OW'(BLANK_CYC);

  logic [OW-1:0] on_cnt;
  logic          cut_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_cnt   <= '0;
      cut_hold <= 1'b0;
    end else begin
      if (!hs_en)           on_cnt <= '0;
      else if (on_cnt < SAT) on_cnt <= on_cnt + 1'b1;
      if (sw_tick)     cut_hold <= 1'b0;
      else if (hs_evt) cut_hold <= 1'b1;
    end
  end

  // R2
  enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R4
  blank_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt |-> ($past(on_cnt) >= SAT));

  // R5
  evt_with_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt |-> !hs_en);

  // R6
  trunc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_evt || cut_hold) && !sw_tick) |=> !hs_en);

  // R7
  valley_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en && ls_en && ls_oc) |=> !hs_en);

  // R8
  ls_evt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_evt |-> $past(sw_tick));

  // R8
  ls_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_evt |=> !ls_evt);

  // R9
  level_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_lvl != 2'b11);
endmodule

bind ocp_gate ocp_gate_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sw_tick (sw_tick),
  .ls_oc   (ls_oc),
  .hs_en   (hs_en),
  .ls_en   (ls_en),
  .hs_evt  (hs_evt),
  .ls_evt  (ls_evt),
  .dac_lvl (dac_lvl)
);

// File: tb/ocp_gate_tb.sv
module ocp_gate_tb;
  localparam int CLK_P = 10;
  localparam int BLANK = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_dem = 1'b0, sw_tick = 1'b0, hs_oc = 1'b0, ls_oc = 1'b0;
  logic [1:0] lvl_sel = 2'b00;
  logic hs_en, ls_en, hs_evt, ls_evt;
  logic [1:0] dac_lvl;

  always #(CLK_P/2) clk = ~clk;

  ocp_gate #(.BLANK_CYC(BLANK)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_dem(pwm_dem), .sw_tick(sw_tick),
    .hs_oc(hs_oc), .ls_oc(ls_oc), .lvl_sel(lvl_sel),
    .hs_en(hs_en), .ls_en(ls_en), .hs_evt(hs_evt), .ls_evt(ls_evt),
    .dac_lvl(dac_lvl)
  );

  // signal ids: 0 hs_en, 1 ls_en, 2 hs_evt, 3 ls_evt, 4 dac_lvl
  typedef struct {
    int    cyc;
    int    sig;
    int    val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sample(input int sig);
    case (sig)
      0: return int'(hs_en);
      1: return int'(ls_en);
      2: return int'(hs_evt);
      3: return int'(ls_evt);
      default: return int'(dac_lvl);
    endcase
  endfunction

  // Monitor: pops what is due this cycle and compares.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      int got;
      e = q.pop_front();
      got = sample(e.sig);
      checks++;
      if (e.cyc != cyc || got != e.val) begin
        errors++;
        $display("FAIL %s sig=%0d cyc=%0d actual=%0d expected=%0d",
                 e.req, e.sig, cyc, got, e.val);
      end
    end
  end

  task automatic expect_sig(input int sig, input int val, input string req);
    exp_t e;
    e.cyc = cyc; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // Drives one cycle of inputs; expectations pushed after it apply to the
  // outputs registered at that edge.
  task automatic step(input logic p, input logic t, input logic h, input logic l);
    pwm_dem = p; sw_tick = t; hs_oc = h; ls_oc = l;
    @(posedge clk); #1;
  endtask

  task automatic expect_hs(input int v, input string req);
    expect_sig(0, v, req);
    expect_sig(1, 1 - v, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    for (int s = 0; s < 5; s++) expect_sig(s, 0, "R1");
    rst_n = 1'b1;

    // R2 complement right after reset
    step(0, 0, 0, 0); expect_hs(0, "R2");

    // R3 demand following
    step(1, 1, 0, 0); expect_hs(1, "R3");
    step(1, 0, 0, 0); expect_hs(1, "R3");
    step(0, 0, 0, 0); expect_hs(0, "R3");

    // R4/R5 flag held past the window truncates
    step(1, 1, 0, 0); expect_hs(1, "R3");
    for (int i = 0; i < BLANK; i++) begin
      step(1, 0, 1, 0); expect_hs(1, "R4"); expect_sig(2, 0, "R4");
    end
    step(1, 0, 1, 0); expect_hs(0, "R5"); expect_sig(2, 1, "R5");
    expect_sig(3, 0, "R8");
    // R6 hold off for the rest of the period
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0); expect_hs(0, "R6"); expect_sig(2, 0, "R5");
    end
    step(1, 1, 0, 0); expect_hs(1, "R6"); expect_sig(3, 0, "R8");

    // R4 flag only inside the window leaves the on-time alone
    for (int i = 0; i < BLANK; i++) begin
      step(1, 0, 1, 0); expect_hs(1, "R4");
    end
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0); expect_hs(1, "R4"); expect_sig(2, 0, "R4");
    end
    step(0, 0, 0, 0); expect_hs(0, "R3");

    // R7/R8 valley limit during low-side conduction
    step(0, 1, 0, 0); expect_hs(0, "R2"); expect_sig(3, 0, "R8");
    step(0, 0, 0, 1); expect_sig(3, 0, "R8");
    step(1, 1, 0, 1); expect_hs(0, "R7"); expect_sig(3, 1, "R8");
    expect_sig(2, 0, "R8");
    step(1, 0, 0, 1); expect_hs(0, "R7"); expect_sig(3, 0, "R8");
    step(1, 0, 0, 0); expect_hs(1, "R7");
    step(1, 0, 0, 1); expect_hs(1, "R7");
    step(0, 1, 0, 0); expect_hs(0, "R3"); expect_sig(3, 1, "R8");
    step(0, 0, 0, 0); expect_sig(3, 0, "R8");
    // R8 valley flag during high-side conduction does not count
    step(1, 1, 0, 0); expect_hs(1, "R3"); expect_sig(3, 0, "R8");
    step(1, 0, 0, 1); expect_hs(1, "R7");
    step(0, 1, 0, 1); expect_hs(0, "R3"); expect_sig(3, 0, "R8");
    step(0, 0, 0, 0); expect_sig(3, 0, "R8");

    // R9 level clamp
    lvl_sel = 2'b11; step(0, 0, 0, 0); expect_sig(4, 2, "R9");
    lvl_sel = 2'b01; step(0, 0, 0, 0); expect_sig(4, 1, "R9");
    lvl_sel = 2'b00; step(0, 0, 0, 0); expect_sig(4, 0, "R9");
    lvl_sel = 2'b10; step(0, 0, 0, 0); expect_sig(4, 2, "R9");

    repeat (3) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard R1 actual=%0d expected=0 pending items", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule